// File: doc/BRIEF.md
# Packet Buffer Host Data Port

This block gives a host a window into packet buffer memory through two registers. A pointer register names the target packet and a byte offset inside it. It also holds two mode bits: automatic advance, and an intent-to-read flag. A data register then moves single bytes or 16-bit words at that offset. The target packet number comes from one of two inputs, chosen by a pointer bit: the head of the receive queue, or the host's own packet number register. The allocator that owns those numbers sits outside the block. The block forms a byte address from the packet's base page (number × 256) plus the offset, and drives a byte-wide synchronous RAM with one cycle of read latency.

Reads are served from a two-byte prefetch buffer. While the read flag is set, a pointer write, any data write and an advancing data read each refill the buffer from the current pointer. `hst_ready` is low while the refill runs, so the next data read always returns the bytes at the pointer. Writes are buffered at the accept edge and then reach the RAM one byte per cycle, low byte first.

The controller has six states. ST_IDLE accepts requests. ST_WR_LO writes the byte at the offset. ST_WR_HI writes the byte at offset+1. ST_FETCH_LO and ST_FETCH_HI issue the two prefetch reads. ST_FETCH_END captures the second byte. The transitions are:
- ST_IDLE goes to ST_WR_LO on a word or lane-0 write.
- ST_IDLE goes to ST_WR_HI on a lane-1 write.
- ST_IDLE goes to ST_FETCH_LO on a pointer write with the read flag set, and on an advancing data read while the read flag is set.
- ST_WR_LO goes to ST_WR_HI for a word.
- ST_WR_LO and ST_WR_HI go to ST_FETCH_LO when the read flag is set, and otherwise to ST_IDLE.
- ST_FETCH_LO goes to ST_FETCH_HI, then to ST_FETCH_END, then back to ST_IDLE.

Top module: `pkt_data_port`

## Requirements
- R1: After reset, `hst_ready` is 1, `ram_en` is 0, the pointer reads back as 0x0000 and a word data read returns 0x0000.
- R2: `hst_reg` codes are 0 pointer, 1 data word, 2 data byte lane 0, 3 data byte lane 1. The pointer holds bit 15 (source is receive head), bit 14 (advance), bit 13 (read intent) and bits 10:0 (offset). A pointer read returns these bits, with bits 12:11 reading 0.
- R3: The RAM byte address is packet × 256 + offset, modulo 2^(PN_W+8). The packet is `rx_head_pkt` when pointer bit 15 is set and `tx_pkt_num` otherwise, sampled at the accept edge. Offset+1 wraps within 11 bits.
- R4: An accepted word write stores `hst_wdata[7:0]` at the offset, in the first cycle after accept. It stores `hst_wdata[15:8]` at offset+1 in the next cycle.
- R5: A lane-0 write stores `hst_wdata[7:0]` at the offset. A lane-1 write stores `hst_wdata[7:0]` at offset+1. Each is one RAM write in the first cycle after accept.
- R6: With bit 14 set, a data word access adds 2 to the offset and a byte access adds 1, wrapping in 11 bits. With bit 14 clear, the offset is unchanged.
- R7: A pointer write with bit 13 set holds `hst_ready` low for exactly 3 cycles. After it, a word read returns {byte at offset+1, byte at offset}, and lane 0 and lane 1 reads return those bytes zero-extended.
- R8: While bit 13 is set, any data write and any advancing data read refill the prefetch buffer from the updated pointer. A read without advance does not refill, and `hst_ready` stays 1.
- R9: A request made while `hst_ready` is 0 is ignored and changes neither the pointer nor the RAM.
- R10: A pointer write with bit 13 clear starts no RAM access, and `hst_ready` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_req | input | 1 | Host access request, taken when `hst_ready` is 1 |
| hst_we | input | 1 | 1 = write, 0 = read |
| hst_reg | input | 2 | Register select (pointer, word, lane 0, lane 1) |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Read data for the selected register, valid in the request cycle |
| hst_ready | output | 1 | Block can accept a request |
| rx_head_pkt | input | PN_W | Packet number at the receive queue head |
| tx_pkt_num | input | PN_W | Host packet number register value |
| ram_en | output | 1 | RAM access strobe |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | PN_W+8 | RAM byte address |
| ram_wdata | output | 8 | RAM write byte |
| ram_rdata | input | 8 | RAM read byte, one cycle after the strobe |

## Verification
A wrong offset or packet choice shows at once on `ram_addr` in the first write cycle after accept. On reads, it shows later, as the wrong bytes from the next data read. A stuck or misrouted controller state shows as `hst_ready` staying low, or recovering after the wrong number of cycles, and this is counted cycle by cycle after a pointer write. A missed refill leaves stale prefetch bytes, which show on the next read after a write or an advancing read.

// File: rtl/pdp_pkg.sv
package pdp_pkg;
    localparam int OFF_W  = 11;
    localparam int BYTE_W = 8;
    localparam int DATA_W = 2 * BYTE_W;
    localparam int PAGE_W = 8;

    typedef enum logic [1:0] {
        REG_PTR   = 2'd0,
        REG_WORD  = 2'd1,
        REG_BYTE0 = 2'd2,
        REG_BYTE1 = 2'd3
    } pdp_reg_e;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_WR_LO     = 3'd1,
        ST_WR_HI     = 3'd2,
        ST_FETCH_LO  = 3'd3,
        ST_FETCH_HI  = 3'd4,
        ST_FETCH_END = 3'd5
    } pdp_state_e;

    typedef struct packed {
        logic             src_rx;
        logic             auto_inc;
        logic             rd_mode;
        logic [OFF_W-1:0] off;
    } pdp_ptr_t;
endpackage

// File: rtl/pdp_ptr_reg.sv
module pdp_ptr_reg
    import pdp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ptr_load,
    input  pdp_ptr_t load_val,
    input  logic     adv_en,
    input  logic     adv_word,
    output pdp_ptr_t ptr_q
);
    logic [OFF_W-1:0] step;

    assign step = adv_word ? OFF_W'(2) : OFF_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (ptr_load) begin
            ptr_q <= load_val;
        end else if (adv_en) begin
            ptr_q.off <= ptr_q.off + step;
        end
    end
endmodule

// File: rtl/pdp_addr_gen.sv
module pdp_addr_gen
    import pdp_pkg::*;
#(
    parameter int PN_W   = 3,
    parameter int ADDR_W = PN_W + PAGE_W
) (
    input  logic [PN_W-1:0]   pkt,
    input  logic [OFF_W-1:0]  off,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] page_base;

    assign page_base = {pkt, {PAGE_W{1'b0}}};
    assign addr      = page_base + ADDR_W'(off);
endmodule

// File: rtl/pdp_prefetch.sv
module pdp_prefetch
    import pdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_lo,
    input  logic              cap_hi,
    input  logic [BYTE_W-1:0] rdata,
    output logic [BYTE_W-1:0] pf_lo,
    output logic [BYTE_W-1:0] pf_hi
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pf_lo <= '0;
            pf_hi <= '0;
        end else begin
            if (cap_lo) pf_lo <= rdata;
            if (cap_hi) pf_hi <= rdata;
        end
    end
endmodule

// File: rtl/pdp_ctrl_fsm.sv
module pdp_ctrl_fsm
    import pdp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     hst_req,
    input  logic     hst_we,
    input  pdp_reg_e reg_sel,
    input  logic     new_rd_mode,
    input  logic     cur_rd_mode,
    input  logic     cur_auto,
    output logic     ready,
    output logic     accept,
    output logic     ram_en,
    output logic     ram_we,
    output logic     hi_sel,
    output logic     wr_phase,
    output logic     cap_lo,
    output logic     cap_hi
);
    pdp_state_e state_q, state_d;
    logic       word_q;

    assign accept = hst_req && (state_q == ST_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            word_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) word_q <= (reg_sel == REG_WORD);
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (hst_we) begin
                        unique case (reg_sel)
                            REG_PTR:   state_d = new_rd_mode ? ST_FETCH_LO : ST_IDLE;
                            REG_WORD,
                            REG_BYTE0: state_d = ST_WR_LO;
                            REG_BYTE1: state_d = ST_WR_HI;
                            default:   state_d = ST_IDLE;
                        endcase
                    end else if (reg_sel != REG_PTR && cur_auto && cur_rd_mode) begin
                        state_d = ST_FETCH_LO;
                    end
                end
            end
            ST_WR_LO: begin
                if (word_q)           state_d = ST_WR_HI;
                else if (cur_rd_mode) state_d = ST_FETCH_LO;
                else                  state_d = ST_IDLE;
            end
            ST_WR_HI:     state_d = cur_rd_mode ? ST_FETCH_LO : ST_IDLE;
            ST_FETCH_LO:  state_d = ST_FETCH_HI;
            ST_FETCH_HI:  state_d = ST_FETCH_END;
            ST_FETCH_END: state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ready    = 1'b0;
        ram_en   = 1'b0;
        ram_we   = 1'b0;
        hi_sel   = 1'b0;
        wr_phase = 1'b0;
        cap_lo   = 1'b0;
        cap_hi   = 1'b0;
        unique case (state_q)
            ST_IDLE:      ready = 1'b1;
            ST_WR_LO: begin
                ram_en   = 1'b1;
                ram_we   = 1'b1;
                wr_phase = 1'b1;
            end
            ST_WR_HI: begin
                ram_en   = 1'b1;
                ram_we   = 1'b1;
                wr_phase = 1'b1;
                hi_sel   = 1'b1;
            end
            ST_FETCH_LO:  ram_en = 1'b1;
            ST_FETCH_HI: begin
                ram_en = 1'b1;
                hi_sel = 1'b1;
                cap_lo = 1'b1;
            end
            ST_FETCH_END: cap_hi = 1'b1;
            default:      ready = 1'b0;
        endcase
    end

    assert_fetch_walk_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH_LO) |=> (state_q == ST_FETCH_HI));
    assert_fetch_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH_HI) |=> (state_q == ST_FETCH_END));
    assert_word_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WR_LO && word_q) |=> (state_q == ST_WR_HI));
    assert_refill_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WR_HI && cur_rd_mode) |=> (state_q == ST_FETCH_LO));
endmodule

// File: rtl/pkt_data_port.sv
module pkt_data_port
    import pdp_pkg::*;
#(
    parameter  int PN_W   = 3,
    localparam int ADDR_W = PN_W + PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hst_req,
    input  logic              hst_we,
    input  logic [1:0]        hst_reg,
    input  logic [DATA_W-1:0] hst_wdata,
    output logic [DATA_W-1:0] hst_rdata,
    output logic              hst_ready,
    input  logic [PN_W-1:0]   rx_head_pkt,
    input  logic [PN_W-1:0]   tx_pkt_num,
    output logic              ram_en,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [BYTE_W-1:0] ram_wdata,
    input  logic [BYTE_W-1:0] ram_rdata
);
    pdp_reg_e          reg_sel;
    pdp_ptr_t          ptr_q;
    pdp_ptr_t          ptr_new;
    logic              accept, hi_sel, wr_phase, cap_lo, cap_hi;
    logic              ptr_load, is_data, adv_en, adv_word, src_now;
    logic [OFF_W-1:0]  acc_off, base_off, byte_off;
    logic [PN_W-1:0]   acc_pkt;
    logic [DATA_W-1:0] wbuf;
    logic [BYTE_W-1:0] pf_lo, pf_hi;

    assign reg_sel  = pdp_reg_e'(hst_reg);
    assign ptr_new  = '{src_rx: hst_wdata[15], auto_inc: hst_wdata[14],
                        rd_mode: hst_wdata[13], off: hst_wdata[OFF_W-1:0]};
    assign is_data  = (reg_sel != REG_PTR);
    assign ptr_load = accept && hst_we && !is_data;
    assign adv_en   = accept && is_data && ptr_q.auto_inc;
    assign adv_word = (reg_sel == REG_WORD);
    assign src_now  = ptr_load ? hst_wdata[15] : ptr_q.src_rx;

    pdp_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hst_req    (hst_req),
        .hst_we     (hst_we),
        .reg_sel    (reg_sel),
        .new_rd_mode(hst_wdata[13]),
        .cur_rd_mode(ptr_q.rd_mode),
        .cur_auto   (ptr_q.auto_inc),
        .ready      (hst_ready),
        .accept     (accept),
        .ram_en     (ram_en),
        .ram_we     (ram_we),
        .hi_sel     (hi_sel),
        .wr_phase   (wr_phase),
        .cap_lo     (cap_lo),
        .cap_hi     (cap_hi)
    );

    pdp_ptr_reg u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ptr_load(ptr_load),
        .load_val(ptr_new),
        .adv_en  (adv_en),
        .adv_word(adv_word),
        .ptr_q   (ptr_q)
    );

    // access context captured at the accept edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_off <= '0;
            acc_pkt <= '0;
            wbuf    <= '0;
        end else if (accept) begin
            acc_off <= ptr_q.off;
            acc_pkt <= src_now ? rx_head_pkt : tx_pkt_num;
            wbuf    <= (reg_sel == REG_BYTE1) ? {hst_wdata[BYTE_W-1:0], {BYTE_W{1'b0}}}
                                              : hst_wdata;
        end
    end

    assign base_off  = wr_phase ? acc_off : ptr_q.off;
    assign byte_off  = base_off + OFF_W'(hi_sel);
    assign ram_wdata = hi_sel ? wbuf[DATA_W-1:BYTE_W] : wbuf[BYTE_W-1:0];

    pdp_addr_gen #(.PN_W(PN_W), .ADDR_W(ADDR_W)) u_addr (
        .pkt (acc_pkt),
        .off (byte_off),
        .addr(ram_addr)
    );

    pdp_prefetch u_pf (
        .clk   (clk),
        .rst_n (rst_n),
        .cap_lo(cap_lo),
        .cap_hi(cap_hi),
        .rdata (ram_rdata),
        .pf_lo (pf_lo),
        .pf_hi (pf_hi)
    );

    always_comb begin
        unique case (reg_sel)
            REG_PTR:   hst_rdata = {ptr_q.src_rx, ptr_q.auto_inc, ptr_q.rd_mode, 2'b00, ptr_q.off};
            REG_WORD:  hst_rdata = {pf_hi, pf_lo};
            REG_BYTE0: hst_rdata = {{BYTE_W{1'b0}}, pf_lo};
            REG_BYTE1: hst_rdata = {{BYTE_W{1'b0}}, pf_hi};
            default:   hst_rdata = '0;
        endcase
    end

    assert_busy_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_req && !hst_ready) |=> $stable(ptr_q));
    assert_word_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && reg_sel == REG_WORD && ptr_q.auto_inc)
        |=> (ptr_q.off == $past(ptr_q.off) + OFF_W'(2)));
    assert_no_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && is_data && !ptr_q.auto_inc) |=> $stable(ptr_q.off));
    assert_quiet_ptr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hst_we && !is_data && !hst_wdata[13]) |=> (hst_ready && !ram_en));
    assert_fetch_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hst_we && !is_data && hst_wdata[13]) |=> (!hst_ready && ram_en && !ram_we));
endmodule

// File: tb/pkt_data_port_tb_top.sv
module pkt_data_port_tb_top;
    localparam int PN_W   = 3;
    localparam int ADDR_W = PN_W + 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              hst_req = 1'b0, hst_we = 1'b0;
    logic [1:0]        hst_reg = 2'd0;
    logic [15:0]       hst_wdata = 16'h0, hst_rdata;
    logic              hst_ready;
    logic [PN_W-1:0]   rx_head_pkt = '0, tx_pkt_num = '0;
    logic              ram_en, ram_we;
    logic [ADDR_W-1:0] ram_addr;
    logic [7:0]        ram_wdata;
    logic [7:0]        ram_rdata = 8'h00;

    logic [7:0] mem  [0:(1<<ADDR_W)-1];
    logic [7:0] gold [0:(1<<ADDR_W)-1];

    int  n_run = 0, n_fail = 0;
    bit  done = 1'b0;

    // bench model of the pointer and prefetch buffer
    logic        e_src = 0, e_auto = 0, e_rd = 0;
    logic [10:0] e_off = 0;
    logic [7:0]  e_lo = 0, e_hi = 0;

    always #2 clk = ~clk;

    pkt_data_port #(.PN_W(PN_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .hst_req(hst_req), .hst_we(hst_we),
        .hst_reg(hst_reg), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .hst_ready(hst_ready), .rx_head_pkt(rx_head_pkt), .tx_pkt_num(tx_pkt_num),
        .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    always @(posedge clk) begin
        if (ram_en) begin
            if (ram_we) mem[ram_addr] <= ram_wdata;
            ram_rdata <= mem[ram_addr];
        end
    end

    function automatic logic [7:0] seed_byte(input int a);
        return 8'((a * 29 + 91) ^ (a >> 3));
    endfunction

    function automatic logic [ADDR_W-1:0] baddr(input logic [PN_W-1:0] p, input logic [10:0] o);
        return {p, 8'h00} + ADDR_W'(o);
    endfunction

    function automatic logic [PN_W-1:0] cur_pkt();
        return e_src ? rx_head_pkt : tx_pkt_num;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_fetch();
        e_lo = gold[baddr(cur_pkt(), e_off)];
        e_hi = gold[baddr(cur_pkt(), e_off + 11'd1)];
    endtask

    task automatic wait_ready();
        while (!hst_ready) @(negedge clk);
    endtask

    // drive one request at a negedge; return at the negedge after the accept edge
    task automatic do_acc(input logic we, input logic [1:0] rg, input logic [15:0] wd,
                          output logic [15:0] rd);
        wait_ready();
        hst_req = 1'b1; hst_we = we; hst_reg = rg; hst_wdata = wd;
        #1 rd = hst_rdata;
        @(negedge clk);
        hst_req = 1'b0;
    endtask

    task automatic ptr_write(input logic [15:0] v);
        logic [15:0] rd;
        do_acc(1'b1, 2'd0, v, rd);
        e_src = v[15]; e_auto = v[14]; e_rd = v[13]; e_off = v[10:0];
        if (e_rd) model_fetch();
        wait_ready();
    endtask

    task automatic ptr_check(input string tag);
        logic [15:0] rd, exp;
        do_acc(1'b0, 2'd0, 16'h0, rd);
        exp = {e_src, e_auto, e_rd, 2'b00, e_off};
        chk(rd === exp, tag, rd, exp);
    endtask

    task automatic data_write(input logic [1:0] rg, input logic [15:0] v);
        logic [15:0] rd;
        logic [PN_W-1:0] p;
        p = cur_pkt();
        do_acc(1'b1, rg, v, rd);
        if (rg == 2'd1 || rg == 2'd2) begin
            chk(ram_en && ram_we && ram_addr == baddr(p, e_off) && ram_wdata == v[7:0],
                (rg == 2'd1) ? "R4 low byte" : "R5 lane0", {5'b0, ram_addr}, {5'b0, baddr(p, e_off)});
            gold[baddr(p, e_off)] = v[7:0];
        end
        if (rg == 2'd1) @(negedge clk);
        if (rg == 2'd1 || rg == 2'd3) begin
            chk(ram_en && ram_we && ram_addr == baddr(p, e_off + 11'd1) &&
                ram_wdata == ((rg == 2'd1) ? v[15:8] : v[7:0]),
                (rg == 2'd1) ? "R4 high byte" : "R5 lane1",
                {ram_wdata, ram_addr[7:0]}, {((rg == 2'd1) ? v[15:8] : v[7:0]), baddr(p, e_off + 11'd1)});
            gold[baddr(p, e_off + 11'd1)] = (rg == 2'd1) ? v[15:8] : v[7:0];
        end
        if (e_auto) e_off = e_off + ((rg == 2'd1) ? 11'd2 : 11'd1);
        if (e_rd) model_fetch();
        wait_ready();
    endtask

    task automatic data_read(input logic [1:0] rg, input string tag);
        logic [15:0] rd, exp;
        do_acc(1'b0, rg, 16'h0, rd);
        exp = (rg == 2'd1) ? {e_hi, e_lo} : (rg == 2'd2) ? {8'h00, e_lo} : {8'h00, e_hi};
        chk(rd === exp, tag, rd, exp);
        if (e_auto) begin
            e_off = e_off + ((rg == 2'd1) ? 11'd2 : 11'd1);
            if (e_rd) model_fetch();
        end
        wait_ready();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        int lowcnt;
        void'($urandom(32'd2024));
        for (int a = 0; a < (1 << ADDR_W); a++) begin
            mem[a]  = seed_byte(a);
            gold[a] = seed_byte(a);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(hst_ready === 1'b1, "R1 ready", {15'b0, hst_ready}, 16'h1);
        chk(ram_en === 1'b0, "R1 ram idle", {15'b0, ram_en}, 16'h0);
        ptr_check("R1 pointer");
        data_read(2'd1, "R1 word");

        // R2 readback with reserved bits masked
        tx_pkt_num = 3'd5; rx_head_pkt = 3'd2;
        ptr_write(16'hFFFF);
        ptr_check("R2 pointer readback");
        do_acc(1'b0, 2'd0, 16'h0, rd);
        chk(rd === 16'hE7FF, "R2 literal", rd, 16'hE7FF);

        // R10 pointer write without read intent
        do_acc(1'b1, 2'd0, 16'h4010, rd);
        e_src = 0; e_auto = 1; e_rd = 0; e_off = 11'h010;
        chk(hst_ready === 1'b1 && ram_en === 1'b0, "R10 no access", {ram_en, 14'b0, hst_ready}, 16'h0001);

        // R4 word write, R6 advance by 2
        data_write(2'd1, 16'hA55A);
        ptr_check("R6 word advance");
        // R5 byte writes, R6 advance by 1
        data_write(2'd3, 16'h003C);
        ptr_check("R6 byte advance");
        data_write(2'd2, 16'h0077);

        // R7 prefetch after pointer write with read intent
        do_acc(1'b1, 2'd0, 16'h6010, rd);
        e_src = 0; e_auto = 1; e_rd = 1; e_off = 11'h010;
        model_fetch();
        lowcnt = 0;
        while (!hst_ready) begin lowcnt++; @(negedge clk); end
        chk(lowcnt == 3, "R7 busy cycles", 16'(lowcnt), 16'd3);
        do_acc(1'b0, 2'd1, 16'h0, rd);
        chk(rd === 16'hA55A, "R7 word literal", rd, 16'hA55A);
        e_off = e_off + 11'd2; model_fetch(); wait_ready();
        data_read(2'd3, "R8 refetch lane1");
        ptr_write(16'h2013);
        data_read(2'd2, "R7 lane0");
        do_acc(1'b0, 2'd2, 16'h0, rd);
        chk(rd === 16'h0077, "R5 lane0 literal", rd, 16'h0077);

        // R8 read without advance: no refill, ready stays high
        ptr_write(16'h2010);
        data_read(2'd1, "R8 no-advance read");
        chk(hst_ready === 1'b1, "R8 no refill", {15'b0, hst_ready}, 16'h1);
        data_read(2'd1, "R8 repeated read");
        ptr_check("R6 offset held");

        // R3 receive source with offset wrap
        rx_head_pkt = 3'd6;
        ptr_write(16'hC7FF);
        data_write(2'd1, 16'hBEEF);
        ptr_check("R3 wrap pointer");
        ptr_write(16'hA7FF);
        data_read(2'd1, "R3 receive-source word");

        // R9 request while busy is ignored
        do_acc(1'b1, 2'd0, 16'h2123, rd);
        e_src = 0; e_auto = 0; e_rd = 1; e_off = 11'h123;
        model_fetch();
        hst_req = 1'b1; hst_we = 1'b1; hst_reg = 2'd1; hst_wdata = 16'h0000;
        @(negedge clk);
        hst_req = 1'b0;
        wait_ready();
        ptr_check("R9 pointer unchanged");
        data_read(2'd1, "R9 memory unchanged");

        // random mix
        for (int i = 0; i < 500; i++) begin
            int unsigned op;
            rx_head_pkt = PN_W'($urandom);
            tx_pkt_num  = PN_W'($urandom);
            op = $urandom % 10;
            if (op < 2)      ptr_write(16'($urandom));
            else if (op < 5) data_write(2'(1 + $urandom % 3), 16'($urandom));
            else if (op < 9) data_read(2'(1 + $urandom % 3), "R3/R7/R8 random read");
            else             ptr_check("R2/R6 random pointer");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule